// File: doc/BRIEF.md
# Store-Queue Flush Address Unit

This unit services a flush of one of two 32-byte store queues. On an accepted request it works out where the queue's line must land in physical memory, checks that the write is allowed, and then streams the eight 32-bit words of the selected queue to a memory write port. Address bit 5 of the flush address picks the queue.

The burst address comes from one of two paths, chosen by a global translation-enable input. With translation off, the address is a fixed remap: part of the flush address combined with a three-bit field from a per-queue area register. With translation on, the unit asks an external TLB for a lookup over a request/response handshake. It then turns the reply into either a translated line address or exactly one exception code.

Data leaves through a valid/ready write port. While `mem_valid` is high and `mem_ready` is low, the address and data hold steady. A word moves only on a cycle where both are high. The flush request itself is valid/ready: `req_ready` is high only while the unit is idle, so a request presented while busy waits. The TLB reply is taken on the first cycle where `tlb_rsp_valid` is high while `tlb_req_valid` is asserted.

Top module: `sq_flush_unit`

## Requirements
- R1: Flush address bit 5 selects the queue. When it is 0 the words come from `sq0_line`; when it is 1 they come from `sq1_line`. Word i of a queue is bits 32i+31:32i of its line input.
- R2: With `xlate_en` low at acceptance, the target is built as follows. Bits 25:5 are the flush address bits 25:5. Bits 28:26 are bits 4:2 of `qarea0` (queue 0) or `qarea1` (queue 1). Bits 31:29 and 4:0 are zero. No TLB request is made.
- R3: With `xlate_en` high, `tlb_req_valid` is raised with `tlb_req_vpn` equal to the flush address. `tlb_req_use_asid` is 0 only when both `single_virt` and `priv_mode` were high at acceptance; otherwise it is 1.
- R4: A miss reply ends the flush with code 1 and no memory write. A multi-hit reply without a miss ends it with code 2 and no memory write. When both are flagged, code 1 wins.
- R5: On a single hit, the write must be permitted. In privileged mode this needs `tlb_rsp_writable` = 1. In user mode it needs `tlb_rsp_user_wr` = 2'b11. Otherwise the flush ends with code 3 and no write, even if the dirty flag is also clear.
- R6: A permitted hit whose `tlb_rsp_dirty` is 0 ends the flush with code 4 and no write.
- R7: A translated target is ((ppn AND mask) OR (flush address AND NOT mask)) with bits 4:0 cleared.
- R8: A successful flush writes eight words at target, target+4, … target+28, with queue word i sent at target+4i. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_valid` do not change.
- R9: `done` is a one-cycle pulse. It comes one cycle after the eighth word's handshake, or one cycle after an exception reply. `exc_code` is valid with it, and is 0 on success.
- R10: After reset the unit is idle. `req_ready` is high only when idle. `busy` is high from the cycle after acceptance through the `done` cycle, and a request held during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Flush request present |
| req_ready | output | 1 | Unit idle, request taken this cycle if valid |
| req_addr | input | 32 | Flush address |
| priv_mode | input | 1 | CPU in privileged mode |
| xlate_en | input | 1 | Global translation enable |
| single_virt | input | 1 | Single-virtual-space mode |
| qarea0 | input | 32 | Queue-area control register for queue 0 |
| qarea1 | input | 32 | Queue-area control register for queue 1 |
| sq0_line | input | 256 | Contents of queue 0 |
| sq1_line | input | 256 | Contents of queue 1 |
| tlb_req_valid | output | 1 | TLB lookup requested |
| tlb_req_vpn | output | 32 | Virtual address to look up |
| tlb_req_use_asid | output | 1 | Lookup must compare the address-space ID |
| tlb_rsp_valid | input | 1 | TLB reply present |
| tlb_rsp_miss | input | 1 | No entry matched |
| tlb_rsp_multi | input | 1 | More than one entry matched |
| tlb_rsp_writable | input | 1 | Entry writable in privileged mode |
| tlb_rsp_user_wr | input | 2 | User write permission bits |
| tlb_rsp_dirty | input | 1 | Entry dirty flag |
| tlb_rsp_ppn | input | 32 | Physical page bits |
| tlb_rsp_mask | input | 32 | Page mask, ones over the page-number bits |
| mem_valid | output | 1 | Write word present |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | 32 | Write word address |
| mem_data | output | 32 | Write word data |
| busy | output | 1 | Flush in progress |
| done | output | 1 | Flush finished, one-cycle pulse |
| exc_code | output | 3 | 0 none, 1 miss, 2 multi-hit, 3 protection, 4 initial write |

## Verification
Count from the falling edge where the request is driven, with the memory always ready and a same-cycle TLB reply. `done` shows up 9 falling edges later for an untranslated flush, 10 for a translated success, and 2 for an exception. The bench samples every output 1 ns after each falling edge and checks the observed `done` cycle against those counts for every run without back-pressure. With back-pressure, each word is recorded on the sampled cycle where valid and ready are both high, so stalls shift the count but never the order or content.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_MISS  = 3'd1,
    EXC_MULTI = 3'd2,
    EXC_PROT  = 3'd3,
    EXC_DIRTY = 3'd4
  } exc_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_LOOK, ST_BURST, ST_FIN
  } st_t;
endpackage

// File: rtl/sq_remap.sv
module sq_remap
  import sq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       qarea,
  output logic [ADDR_W-1:0] target
);
  logic unused_bits;
  assign unused_bits = ^{addr[ADDR_W-1:26], addr[OFF_W-1:0], qarea[31:5], qarea[1:0]};

  always_comb begin
    target        = '0;
    target[25:OFF_W] = addr[25:OFF_W];
    target[28:26] = qarea[4:2];
  end
endmodule

// File: rtl/sq_tlb_check.sv
module sq_tlb_check
  import sq_pkg::*;
(
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              priv,
  input  logic              miss,
  input  logic              multi,
  input  logic              writable,
  input  logic [1:0]        user_wr,
  input  logic              dirty,
  input  logic [ADDR_W-1:0] ppn,
  input  logic [ADDR_W-1:0] mask,
  output exc_t              exc,
  output logic [ADDR_W-1:0] target
);
  logic denied;
  assign denied = priv ? !writable : (user_wr != 2'b11);

  always_comb begin
    if (miss)        exc = EXC_MISS;
    else if (multi)  exc = EXC_MULTI;
    else if (denied) exc = EXC_PROT;
    else if (!dirty) exc = EXC_DIRTY;
    else             exc = EXC_NONE;
  end

  always_comb begin
    target = (ppn & mask) | (vaddr & ~mask);
    target[OFF_W-1:0] = '0;
  end
endmodule

// File: rtl/sq_burst.sv
module sq_burst
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LINE_W-1:0] line,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              last
);
  localparam int CNT_W  = $clog2(LINE_WORDS);
  localparam int BSHIFT = $clog2(WORD_W / 8);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base_q;
  logic              active;

  assign mem_valid = active;
  assign mem_addr  = base_q + (ADDR_W'(cnt) << BSHIFT);
  assign mem_data  = line[cnt*WORD_W +: WORD_W];
  assign last      = active && mem_ready && (cnt == CNT_W'(LINE_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      base_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      base_q <= base;
    end else if (active && mem_ready) begin
      cnt <= cnt + 1'b1;
      if (last) active <= 1'b0;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[BSHIFT-1:0] == '0));
endmodule

// File: rtl/sq_flush_unit.sv
module sq_flush_unit
  import sq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                priv_mode,
  input  logic                xlate_en,
  input  logic                single_virt,
  input  logic [31:0]         qarea0,
  input  logic [31:0]         qarea1,
  input  logic [LINE_W-1:0]   sq0_line,
  input  logic [LINE_W-1:0]   sq1_line,
  output logic                tlb_req_valid,
  output logic [ADDR_W-1:0]   tlb_req_vpn,
  output logic                tlb_req_use_asid,
  input  logic                tlb_rsp_valid,
  input  logic                tlb_rsp_miss,
  input  logic                tlb_rsp_multi,
  input  logic                tlb_rsp_writable,
  input  logic [1:0]          tlb_rsp_user_wr,
  input  logic                tlb_rsp_dirty,
  input  logic [ADDR_W-1:0]   tlb_rsp_ppn,
  input  logic [ADDR_W-1:0]   tlb_rsp_mask,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_data,
  output logic                busy,
  output logic                done,
  output logic [2:0]          exc_code
);
  st_t               st;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_priv, lat_sv, qsel;
  exc_t              exc_q, chk_exc;
  logic [ADDR_W-1:0] remap_tgt, chk_tgt;
  logic              accept, rsp_take, burst_start, burst_last;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign rsp_take = (st == ST_LOOK) && tlb_rsp_valid;

  sq_remap u_remap (
    .addr   (req_addr),
    .qarea  (req_addr[OFF_W] ? qarea1 : qarea0),
    .target (remap_tgt)
  );

  sq_tlb_check u_check (
    .vaddr    (lat_addr),
    .priv     (lat_priv),
    .miss     (tlb_rsp_miss),
    .multi    (tlb_rsp_multi),
    .writable (tlb_rsp_writable),
    .user_wr  (tlb_rsp_user_wr),
    .dirty    (tlb_rsp_dirty),
    .ppn      (tlb_rsp_ppn),
    .mask     (tlb_rsp_mask),
    .exc      (chk_exc),
    .target   (chk_tgt)
  );

  assign burst_start = (accept && !xlate_en) || (rsp_take && chk_exc == EXC_NONE);

  sq_burst u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (burst_start),
    .base      ((st == ST_IDLE) ? remap_tgt : chk_tgt),
    .line      (qsel ? sq1_line : sq0_line),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .last      (burst_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lat_addr <= '0;
      lat_priv <= 1'b0;
      lat_sv   <= 1'b0;
      qsel     <= 1'b0;
      exc_q    <= EXC_NONE;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          lat_addr <= req_addr;
          lat_priv <= priv_mode;
          lat_sv   <= single_virt;
          qsel     <= req_addr[OFF_W];
          exc_q    <= EXC_NONE;
          st       <= xlate_en ? ST_LOOK : ST_BURST;
        end
        ST_LOOK: if (tlb_rsp_valid) begin
          exc_q <= chk_exc;
          st    <= (chk_exc == EXC_NONE) ? ST_BURST : ST_FIN;
        end
        ST_BURST: if (burst_last) st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready        = (st == ST_IDLE);
  assign busy             = (st != ST_IDLE);
  assign done             = (st == ST_FIN);
  assign exc_code         = exc_q;
  assign tlb_req_valid    = (st == ST_LOOK);
  assign tlb_req_vpn      = lat_addr;
  assign tlb_req_use_asid = !(lat_sv && lat_priv);

  p_one_activity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, mem_valid, tlb_req_valid}));

  p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));

  p_no_write_on_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && tlb_rsp_valid && chk_exc != EXC_NONE) |=> (done && !mem_valid));

  p_burst_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && $past(mem_valid) && !burst_last) |=> mem_valid);
endmodule

// File: tb/sq_flush_unit_tb.sv
`timescale 1ns/1ps
module sq_flush_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         req_valid = 0, priv_mode = 0, xlate_en = 0, single_virt = 0;
  logic [31:0]  req_addr = 0, qarea0 = 0, qarea1 = 0;
  logic [255:0] sq0_line, sq1_line;
  logic         req_ready, tlb_req_valid, tlb_req_use_asid, tlb_rsp_valid;
  logic [31:0]  tlb_req_vpn;
  logic         t_miss = 0, t_multi = 0, t_wr = 0, t_dirty = 0;
  logic [1:0]   t_uwr = 0;
  logic [31:0]  t_ppn = 0, t_mask = 0;
  logic         mem_valid, mem_ready = 1, busy, done;
  logic [31:0]  mem_addr, mem_data;
  logic [2:0]   exc_code;

  assign tlb_rsp_valid = tlb_req_valid;

  sq_flush_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .priv_mode(priv_mode), .xlate_en(xlate_en),
    .single_virt(single_virt), .qarea0(qarea0), .qarea1(qarea1),
    .sq0_line(sq0_line), .sq1_line(sq1_line),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
    .tlb_req_use_asid(tlb_req_use_asid), .tlb_rsp_valid(tlb_rsp_valid),
    .tlb_rsp_miss(t_miss), .tlb_rsp_multi(t_multi), .tlb_rsp_writable(t_wr),
    .tlb_rsp_user_wr(t_uwr), .tlb_rsp_dirty(t_dirty), .tlb_rsp_ppn(t_ppn),
    .tlb_rsp_mask(t_mask), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done),
    .exc_code(exc_code)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      sq0_line[i*32 +: 32] = 32'hA0C0_0000 + i;
      sq1_line[i*32 +: 32] = 32'hB1D0_0000 + i;
    end
  end

  // One flush: drive request, observe until done, check everything.
  task automatic run(input string req, input logic [31:0] addr, input bit xl,
                     input bit pr, input bit sv, input bit stall, input bit hold,
                     input logic [2:0] exp_code, input logic [31:0] exp_tgt);
    logic [31:0] ga [8];
    logic [31:0] gd [8];
    int nw = 0, lat = -1;
    bit seen_tlb = 0, asid = 0, ctl_ok = 1, words_ok = 1;
    bit qs = addr[5];
    int exp_lat;
    @(negedge clk);
    req_addr = addr; xlate_en = xl; priv_mode = pr; single_virt = sv;
    req_valid = 1;
    for (int cyc = 1; cyc < 200; cyc++) begin
      @(negedge clk);
      if (!hold) req_valid = 0;
      else req_addr = addr ^ 32'h0000_1000;
      mem_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (busy !== 1'b1 || req_ready !== 1'b0) ctl_ok = 0;
      if (tlb_req_valid) begin
        seen_tlb = 1; asid = tlb_req_use_asid;
        if (tlb_req_vpn !== addr) ctl_ok = 0;
      end
      if (mem_valid && mem_ready) begin
        if (nw < 8) begin ga[nw] = mem_addr; gd[nw] = mem_data; end
        nw++;
      end
      if (done) begin lat = cyc; break; end
    end
    req_valid = 0; mem_ready = 1;
    check(exc_code === exp_code, req, "exception code", 32'(exc_code), 32'(exp_code));
    check(nw == ((exp_code == 0) ? 8 : 0), req, "word count", nw, (exp_code == 0) ? 8 : 0);
    for (int i = 0; i < 8 && i < nw; i++) begin
      logic [31:0] ed;
      ed = (qs ? 32'hB1D0_0000 : 32'hA0C0_0000) + i;
      if (ga[i] !== exp_tgt + 32'(4*i) || gd[i] !== ed) begin
        words_ok = 0;
        $display("FAIL %s word %0d: actual %h/%h expected %h/%h", req, i,
                 ga[i], gd[i], exp_tgt + 32'(4*i), ed);
      end
    end
    n_chk++; if (!words_ok) n_bad++;
    check(ctl_ok, "R10", {req, " busy/ready while in flight"}, 32'(ctl_ok), 1);
    check(seen_tlb == xl, "R3", {req, " tlb request presence"}, 32'(seen_tlb), 32'(xl));
    if (xl)
      check(asid == !(sv && pr), "R3", {req, " asid compare"}, 32'(asid), 32'(!(sv && pr)));
    if (!stall) begin
      exp_lat = (exp_code != 0) ? 2 : (xl ? 10 : 9);
      check(lat == exp_lat, "R9", {req, " done cycle"}, lat, exp_lat);
    end
    @(negedge clk); #1;
    check(done === 0 && req_ready === 1, "R9", {req, " done one pulse"}, 32'(done), 0);
  endtask

  task automatic set_tlb(input bit mi, input bit mu, input bit wr, input logic [1:0] uw,
                         input bit dt, input logic [31:0] ppn, input logic [31:0] mask);
    t_miss = mi; t_multi = mu; t_wr = wr; t_uwr = uw; t_dirty = dt;
    t_ppn = ppn; t_mask = mask;
  endtask

  task automatic t_reset;
    #1;
    check(req_ready === 1 && busy === 0 && done === 0 && mem_valid === 0 && tlb_req_valid === 0,
          "R10", "reset idle state", {27'd0, req_ready, busy, done, mem_valid, tlb_req_valid}, 32'h10);
  endtask

  task automatic t_remap;
    qarea0 = 32'h0000_0014; qarea1 = 32'hFFFF_FFE8;
    // R1 R2: queue 0, bits 4:2 of qarea0 = 3'b101
    run("R2", 32'hE123_4584, 0, 1, 0, 0, 0, 0, (32'hE123_4584 & 32'h03FF_FFE0) | (32'd5 << 26));
    // R1 R8: queue 1 with back-pressure, qarea1 bits 4:2 = 3'b010
    run("R1", 32'hFC00_03A0, 0, 0, 0, 1, 0, 0, (32'hFC00_03A0 & 32'h03FF_FFE0) | (32'd2 << 26));
  endtask

  task automatic t_xlate_ok;
    set_tlb(0, 0, 1, 2'b00, 1, 32'h0C34_5000, 32'hFFFF_F000);
    run("R7", 32'h7000_0ABC, 1, 1, 1, 0, 0, 0, 32'h0C34_5AA0);
    set_tlb(0, 0, 0, 2'b11, 1, 32'h1FF0_0000, 32'hFFF0_0000);
    run("R5", 32'h4012_3460, 1, 0, 1, 1, 0, 0, 32'h1FF2_3460);
  endtask

  task automatic t_errors;
    set_tlb(1, 1, 1, 2'b11, 1, 0, 32'hFFFF_F000);
    run("R4", 32'h1000_0000, 1, 1, 0, 0, 0, 1, 0);
    set_tlb(0, 1, 1, 2'b11, 1, 0, 32'hFFFF_F000);
    run("R4", 32'h1000_0020, 1, 0, 0, 0, 0, 2, 0);
    set_tlb(0, 0, 0, 2'b11, 1, 0, 32'hFFFF_F000);
    run("R5", 32'h2000_0000, 1, 1, 0, 0, 0, 3, 0);
    set_tlb(0, 0, 1, 2'b01, 1, 0, 32'hFFFF_F000);
    run("R5", 32'h2000_0020, 1, 0, 1, 0, 0, 3, 0);
    set_tlb(0, 0, 0, 2'b11, 0, 0, 32'hFFFF_F000);
    run("R6", 32'h3000_0000, 1, 1, 1, 0, 0, 3, 0);
    set_tlb(0, 0, 1, 2'b00, 0, 0, 32'hFFFF_F000);
    run("R6", 32'h3000_0040, 1, 1, 0, 0, 0, 4, 0);
  endtask

  task automatic t_held_req;
    qarea0 = 32'h0000_001C;
    run("R10", 32'h0155_5540, 0, 0, 0, 0, 1, 0, (32'h0155_5540 & 32'h03FF_FFE0) | (32'd7 << 26));
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_remap();
    t_xlate_ok();
    t_errors();
    t_held_req();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule